// File: doc/BRIEF.md
# Three-Wire Converter Write Master

This block sits on the host side of a serial-input digital-to-analog converter and turns one parallel code request into one write frame on a three-wire link: an active-low select, a serial clock and a serial data line. A request is offered with a valid/ready handshake. Once it is taken, the block lowers select, sends the frame most significant bit first with data that changes only on clock falls, raises select to make the converter commit the code, and pulses a done strobe.

The serial clock comes from the system clock through a divider. The divider value is a runtime input that is captured when a request is accepted. The half period it gives is never shorter than a floor computed from the system clock rate, so the serial clock never runs faster than 50 MHz. The frame carries either 16 or 14 bits. A 14-bit code can also be sent in a 16-clock frame, with two zero bits placed ahead of the code. The block keeps the select setup and hold margins around the clock burst. It holds the clock low while select rises, and it keeps select high for a minimum gap before it starts the next frame.

Top module: `dac3w_writer`

## Requirements
- R1: After reset, dac_cs_n is 1, dac_sclk is 0, req_ready is 1 and frame_done is 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready stays 0 from acceptance until the gap after the frame ends. A request offered while req_ready is 0 is held and sent later, and every accepted request produces exactly one frame.
- R3: A frame has 16 rising edges of dac_sclk when CODE_W is 16, or when CODE_W is 14 with PAD_TO_16 set. Otherwise it has CODE_W rising edges.
- R4: Bits go out most significant bit first and are valid at each dac_sclk rise. The code fills the last CODE_W bits of the frame, and any leading pad bits are 0.
- R5: dac_sclk idles at 0 and is 1 only while dac_cs_n is 0. dac_sdo changes only while dac_sclk is 0.
- R6: Every high phase and low phase of dac_sclk inside a frame lasts H system cycles. H = max(half_div, MIN_HALF), where MIN_HALF = ceil(SYS_MHZ / 100), so the serial clock never exceeds 50 MHz.
- R7: The first dac_sclk rise comes exactly H system cycles after dac_cs_n falls.
- R8: dac_cs_n rises exactly 2H cycles after the last dac_sclk rise. dac_sclk stays 0 through the last H cycles before that rise and in the cycle of the rise.
- R9: frame_done is a one-cycle pulse in the cycle in which dac_cs_n rises, and it occurs at no other time.
- R10: Between two frames, dac_cs_n stays 1 for at least 4H system cycles, where H is that of the earlier frame.
- R11: half_div is captured at acceptance. A change to it during a frame does not change that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Code request offered |
| req_code | input | CODE_W | Code to write |
| req_ready | output | 1 | Block can accept a request |
| half_div | input | DIV_W | Requested half period of the serial clock, in system cycles |
| dac_cs_n | output | 1 | Active-low frame select |
| dac_sclk | output | 1 | Serial clock, idle low |
| dac_sdo | output | 1 | Serial data, MSB first |
| frame_done | output | 1 | One-cycle pulse when the code is committed |

## Verification
The bench builds the block with CODE_W = 14, PAD_TO_16 = 1 and SYS_MHZ = 200, which gives a floor of two system cycles per half period. This covers the padded 16-clock frame and its two leading zero bits. Divider requests of 0 and 1 exercise the clamp to the floor, and larger values exercise longer half periods. Requests are issued back to back while the block is busy, so every frame after the first starts at the minimum select gap. The divider input is changed right after each acceptance, which exposes any failure to capture it.

// File: rtl/dac3w_pkg.sv
// Shared types and helpers for the three-wire converter write master.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package dac3w_pkg;

    // Frame sequencer states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_SHIFT = 3'd2,
        ST_TRAIL = 3'd3,
        ST_GAP   = 3'd4
    } wr_state_t;

    // Smallest half period (system cycles) keeping sclk at or below max_mhz
    function automatic int min_half(input int sys_mhz, input int max_mhz);
        int h;
        h = (sys_mhz + 2 * max_mhz - 1) / (2 * max_mhz);
        return (h < 1) ? 1 : h;
    endfunction

endpackage

// File: rtl/dac3w_tick.sv
// Half-period tick generator for the serial clock.
// Captures the requested half period on load, clamped up to MIN_HALF,
// and emits a one-cycle tick every captured-half-period cycles while run is high.
// Assumes MIN_HALF fits in DIV_W bits.
module dac3w_tick #(
    parameter int DIV_W    = 8,
    parameter int MIN_HALF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] half_in,
    input  logic             run,
    output logic             tick
);
    localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_HALF);

    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half_eff;

    // Clamp the request to the rate floor
    always_comb begin
        half_eff = (half_in < FLOOR) ? FLOOR : half_in;
    end

    // Hold the half period for the whole frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= FLOOR;
        end else if (load) begin
            half_q <= half_eff;
        end
    end

    // Count system cycles within the current half period
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // A tick marks the last cycle of a half period
    always_comb begin
        tick = run && (cnt_q == half_q - DIV_W'(1));
    end

    AST_HALF_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (half_q >= FLOOR)); // R6

endmodule

// File: rtl/dac3w_shifter.sv
// Parallel-in, serial-out register for one frame.
// Loads the code right-aligned in FRAME_W bits with zero pad bits on top,
// and presents the MSB; each shift moves the next bit to the MSB.
// Assumes FRAME_W >= CODE_W.
module dac3w_shifter #(
    parameter int CODE_W  = 16,
    parameter int FRAME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    input  logic              shift,
    output logic              msb
);
    logic [FRAME_W-1:0] sreg_q;

    // Load a new frame or advance one bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load) begin
            sreg_q <= FRAME_W'(code);
        end else if (shift) begin
            sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
        end
    end

    // Serial output is always the top bit
    always_comb begin
        msb = sreg_q[FRAME_W-1];
    end

endmodule

// File: rtl/dac3w_seq.sv
// Frame sequencer: owns select, serial clock, done and the handshake.
// Each phase lasts one half period (tick to tick): a lead half with select low
// and clock low, FRAME_W clock pulses, a trail half with clock low, then select
// rises with done, followed by a gap of GAP_HALVES halves before idle.
// Assumes tick is a one-cycle strobe that runs only while run is high.
module dac3w_seq
    import dac3w_pkg::*;
#(
    parameter int FRAME_W    = 16,
    parameter int GAP_HALVES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic tick,
    output logic ready,
    output logic load,
    output logic shift,
    output logic run,
    output logic cs_n,
    output logic sclk,
    output logic done
);
    localparam int BIT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam int GAP_W = $clog2(GAP_HALVES + 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
    localparam logic [GAP_W-1:0] LAST_GAP = GAP_W'(GAP_HALVES - 1);

    wr_state_t        state_q;
    logic [BIT_W-1:0] bit_q;
    logic [GAP_W-1:0] gap_q;
    logic             cs_n_q;
    logic             sclk_q;
    logic             done_q;
    logic             last_bit;

    // Handshake and datapath strobes
    always_comb begin
        ready    = (state_q == ST_IDLE);
        load     = ready && req_valid;
        run      = (state_q != ST_IDLE);
        last_bit = (bit_q == LAST_BIT);
        shift    = (state_q == ST_SHIFT) && tick && sclk_q && !last_bit;
    end

    // Phase sequencing of select, clock and done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            gap_q   <= '0;
            cs_n_q  <= 1'b1;
            sclk_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (load) begin
                        state_q <= ST_LEAD;
                        cs_n_q  <= 1'b0;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        state_q <= ST_SHIFT;
                        sclk_q  <= 1'b1;
                        bit_q   <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (sclk_q) begin
                            sclk_q <= 1'b0;
                            if (last_bit) begin
                                state_q <= ST_TRAIL;
                            end else begin
                                bit_q <= bit_q + BIT_W'(1);
                            end
                        end else begin
                            sclk_q <= 1'b1;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        state_q <= ST_GAP;
                        cs_n_q  <= 1'b1;
                        done_q  <= 1'b1;
                        gap_q   <= '0;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_q == LAST_GAP) begin
                            state_q <= ST_IDLE;
                        end else begin
                            gap_q <= gap_q + GAP_W'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Registered pins
    always_comb begin
        cs_n = cs_n_q;
        sclk = sclk_q;
        done = done_q;
    end

    AST_READY_LOW_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_q |-> !ready); // R2
    AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_q |-> !cs_n_q); // R5
    AST_SCLK_QUIET_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_q) |-> (!sclk_q && $past(!sclk_q))); // R8
    AST_DONE_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $rose(cs_n_q)); // R9

endmodule

// File: rtl/dac3w_writer.sv
// Three-wire converter write master (top).
// Accepts a code over valid/ready and sends one select-framed, MSB-first
// serial write; the divider request is clamped so sclk stays <= SCLK_MAX_MHZ.
// Assumes CODE_W is 14 or 16; PAD_TO_16 only has effect when CODE_W < 16.
module dac3w_writer
    import dac3w_pkg::*;
#(
    parameter int CODE_W       = 16,
    parameter bit PAD_TO_16    = 1'b0,
    parameter int SYS_MHZ      = 200,
    parameter int SCLK_MAX_MHZ = 50,
    parameter int DIV_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CODE_W-1:0] req_code,
    output logic              req_ready,
    input  logic [DIV_W-1:0]  half_div,
    output logic              dac_cs_n,
    output logic              dac_sclk,
    output logic              dac_sdo,
    output logic              frame_done
);
    localparam int FRAME_W  = (PAD_TO_16 && (CODE_W < 16)) ? 16 : CODE_W;
    localparam int MIN_HALF = min_half(SYS_MHZ, SCLK_MAX_MHZ);

    logic load;
    logic shift;
    logic run;
    logic tick;

    dac3w_tick #(
        .DIV_W    (DIV_W),
        .MIN_HALF (MIN_HALF)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .half_in (half_div),
        .run     (run),
        .tick    (tick)
    );

    dac3w_shifter #(
        .CODE_W  (CODE_W),
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .code  (req_code),
        .shift (shift),
        .msb   (dac_sdo)
    );

    dac3w_seq #(
        .FRAME_W    (FRAME_W),
        .GAP_HALVES (4)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .tick      (tick),
        .ready     (req_ready),
        .load      (load),
        .shift     (shift),
        .run       (run),
        .cs_n      (dac_cs_n),
        .sclk      (dac_sclk),
        .done      (frame_done)
    );

    AST_SDO_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sclk |-> $stable(dac_sdo)); // R5

endmodule

// File: tb/dac3w_writer_test.sv
module dac3w_writer_test;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 14;
    localparam int FRAME_W    = 16;
    localparam int SYS_MHZ    = 200;
    localparam int MIN_H      = (SYS_MHZ + 99) / 100;
    localparam int N_RAND     = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [13:0] req_code = '0;
    logic [7:0]  half_div = '0;
    logic        req_ready, dac_cs_n, dac_sclk, dac_sdo, frame_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [13:0] exp_code [0:63];
    int          exp_h    [0:63];
    int wr_idx = 0;
    int rd_idx = 0;

    dac3w_writer #(
        .CODE_W    (CODE_W),
        .PAD_TO_16 (1'b1),
        .SYS_MHZ   (SYS_MHZ),
        .DIV_W     (8)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_code   (req_code),
        .req_ready  (req_ready),
        .half_div   (half_div),
        .dac_cs_n   (dac_cs_n),
        .dac_sclk   (dac_sclk),
        .dac_sdo    (dac_sdo),
        .frame_done (frame_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int eff_h(input logic [7:0] hd);
        return (int'(hd) < MIN_H) ? MIN_H : int'(hd);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Monitor state
    bit          mon_en = 1'b0;
    logic        p_cs = 1'b1, p_clk = 1'b0, p_sdo = 1'b0;
    int          t_csl = 0, t_csr = 0, t_rise = 0, t_fall = 0;
    int          cur_h = 0, last_h = 0, nbits = 0;
    bit          have_frame = 1'b0;
    logic [15:0] cap = '0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (p_cs && !dac_cs_n) begin
                if (have_frame) check((cyc - t_csr) >= 4 * last_h, "R10 gap", cyc - t_csr, 4 * last_h);
                cur_h = exp_h[rd_idx];
                t_csl = cyc; nbits = 0; cap = '0;
            end
            if (!p_clk && dac_sclk) begin
                if (nbits == 0) check((cyc - t_csl) == cur_h, "R7 lead", cyc - t_csl, cur_h);
                else            check((cyc - t_fall) == cur_h, "R6 low half", cyc - t_fall, cur_h);
                t_rise = cyc;
                cap = {cap[14:0], dac_sdo};
                nbits++;
            end
            if (p_clk && !dac_sclk) begin
                check((cyc - t_rise) == cur_h, "R6 high half", cyc - t_rise, cur_h);
                t_fall = cyc;
            end
            if (!p_cs && dac_cs_n) begin
                check(nbits == FRAME_W, "R3 bit count", nbits, FRAME_W);
                check(cap[13:0] == exp_code[rd_idx], "R4 code", int'(cap[13:0]), int'(exp_code[rd_idx]));
                check(cap[15:14] == 2'b00, "R4 pad", int'(cap[15:14]), 0);
                check((cyc - t_rise) == 2 * cur_h, "R8 trail", cyc - t_rise, 2 * cur_h);
                check(!dac_sclk && (cyc - t_fall) >= cur_h, "R8 sclk quiet", int'(dac_sclk), 0);
                check(frame_done == 1'b1, "R9 done at commit", int'(frame_done), 1);
                rd_idx++;
                t_csr = cyc; last_h = cur_h; have_frame = 1'b1;
            end else if (frame_done) begin
                check(1'b0, "R9 stray done", 1, 0);
            end
            if (!dac_cs_n && req_ready) check(1'b0, "R2 ready in frame", 1, 0);
            if (dac_sclk && dac_cs_n) check(1'b0, "R5 sclk outside frame", 1, 0);
            if (dac_sclk && p_clk && (dac_sdo != p_sdo)) check(1'b0, "R5 sdo moved while high", int'(dac_sdo), int'(p_sdo));
            p_cs = dac_cs_n; p_clk = dac_sclk; p_sdo = dac_sdo;
        end
    end

    // Offer a request, wait for acceptance, then disturb the divider (R11)
    task automatic send(input logic [13:0] code, input logic [7:0] hd);
        @(negedge clk);
        req_valid = 1'b1; req_code = code; half_div = hd;
        while (!req_ready) @(negedge clk);
        exp_code[wr_idx] = code; exp_h[wr_idx] = eff_h(hd); wr_idx++;
        @(negedge clk);
        req_valid = 1'b0;
        half_div = 8'($urandom_range(0, 12));
        req_code = 14'($urandom);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(dac_cs_n == 1'b1, "R1 cs_n", int'(dac_cs_n), 1);
        check(dac_sclk == 1'b0, "R1 sclk", int'(dac_sclk), 0);
        check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        check(frame_done == 1'b0, "R1 done", int'(frame_done), 0);
        mon_en = 1'b1;
        // Directed corners: clamp (R6), extremes of code (R4), back-to-back (R2, R10)
        send(14'h3FFF, 8'd0);
        send(14'h0000, 8'd1);
        send(14'h2AAA, 8'd2);
        send(14'h1555, 8'd9);
        send(14'h2001, 8'd3);
        for (int i = 0; i < N_RAND; i++) begin
            send(14'($urandom), 8'($urandom_range(0, 7)));
        end
        while (rd_idx < wr_idx) @(negedge clk);
        repeat (40) @(negedge clk);
        check(rd_idx == wr_idx, "R2 frames per request", rd_idx, wr_idx);
        check(req_ready == 1'b1 && dac_cs_n == 1'b1, "R2 idle after run", int'(req_ready), 1);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule